// File: doc/BRIEF.md
# Transmit Mailbox Status Tracker

This block holds the status of three CAN transmit mailboxes as one 32-bit word that software reads. Each mailbox owns one byte of that word, carrying sticky completion, success, arbitration-lost and error flags plus a stop request that software raises. The upper byte shows which mailboxes are empty and which pending mailbox sits last in the send order. The frame engine reports starts and ends per mailbox. Software loads frames and writes the word to clear flags or request a stop.

A small rank queue records the order in which mailboxes were filled. When two or more frames are pending, the mailbox holding the last rank is flagged. Removing a mailbox, through a finished frame or an abort, closes the gap in the queue. Loads that arrive together are queued lowest index first.

Top module: `canTxStatus`

## Requirements
- R1: While reset is held and right after it, the status word reads 0x1C00_0000.
- R2: Mailbox n (0..2) uses bits 8n+7..8n: bit 8n finished, 8n+1 success, 8n+2 arbitration lost, 8n+3 error, 8n+7 stop request, with 8n+6..8n+4 reading 0. Bit 26+n is the empty flag, bit 29+n the last-in-order flag, and bits 25..24 read 0.
- R3: A load pulse on an empty mailbox clears its empty flag at the next edge. A load on a mailbox that is not empty is ignored.
- R4: A frame end on a pending mailbox sets its finished flag. It also sets success for result code 0, arbitration lost for code 1 or error for code 2. The mailbox becomes empty and its stop request clears.
- R5: Writing 1 to a finished, success, arbitration-lost or error bit clears it. Writing 0 leaves it unchanged.
- R6: When the hardware sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R7: Writing 1 to the stop bit of a pending mailbox that has not started aborts it at that edge. Its empty and finished flags set, success stays clear, and the stop bit reads 0.
- R8: Writing 1 to the stop bit of a mailbox that has started, including in its start cycle, sets the stop bit. The bit holds until that frame ends.
- R9: Writes to the stop bit of an empty mailbox, and writes to the empty and last-in-order bits, have no effect.
- R10: The last-in-order flag is set only for the most recently queued pending mailbox, and only when two or more mailboxes are pending. The order closes up when any mailbox leaves the queue.
- R11: Mailboxes loaded in the same cycle join the queue in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mbLoad | input | 3 | Per-mailbox frame load pulse from software |
| txStart | input | 3 | Per-mailbox transmission start pulse from the engine |
| txEnd | input | 3 | Per-mailbox frame end pulse from the engine |
| txResult | input | 2 | Result code with txEnd: 0 success, 1 arbitration lost, 2 error |
| regWrEn | input | 1 | Status word write strobe |
| regWrData | input | 32 | Write data: write-1-to-clear flags and stop requests |
| statusWord | output | 32 | Status word |

## Verification
Two kinds of event can land on the same mailbox in one cycle. First, a frame end can coincide with a software write-1-clear of that mailbox's flags. The bench drives both together and expects the flags the end sets to survive, while the flag it does not set is cleared. Second, a stop write can coincide with the start pulse. The bench expects the stop to be held, not to abort the frame, and to clear only at the frame end.

// File: rtl/canTxPkg.sv
package canTxPkg;

  localparam int SLOT_W     = 8;
  localparam int FIN_BIT    = 0;
  localparam int OK_BIT     = 1;
  localparam int ARB_BIT    = 2;
  localparam int ERR_BIT    = 3;
  localparam int STOP_BIT   = 7;
  localparam int EMPTY_BASE = 26;
  localparam int LAST_BASE  = 29;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_ARB = 2'd1,
    RES_ERR = 2'd2
  } txResult_e;

  // strobes from the control to the flag datapath, one set per mailbox
  typedef struct packed {
    logic setFin;
    logic setOk;
    logic setArb;
    logic setErr;
    logic markEmpty;
    logic markFull;
    logic setStop;
    logic clrStop;
  } mbStrobe_t;

endpackage

// File: rtl/canTxOrderCtl.sv
module canTxOrderCtl
  import canTxPkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int CNT_W  = $clog2(NUM_MB + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_MB-1:0]            mbLoad,
  input  logic [NUM_MB-1:0]            txStart,
  input  logic [NUM_MB-1:0]            txEnd,
  input  logic [1:0]                   txResult,
  input  logic [NUM_MB-1:0]            wrStop,
  input  logic [NUM_MB-1:0]            emptyQ,
  output mbStrobe_t [NUM_MB-1:0]       strobe,
  output logic [NUM_MB-1:0]            lastMb
);

  logic [NUM_MB-1:0] busyQ, doLoad, endEv, stopWr, abortNow, removeEv, survive;
  logic [CNT_W-1:0]  rankQ [NUM_MB];
  logic [CNT_W-1:0]  rankD [NUM_MB];
  logic [CNT_W-1:0]  pendCnt, survCnt;

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      doLoad[i]   = mbLoad[i] && emptyQ[i];
      endEv[i]    = txEnd[i] && !emptyQ[i];
      stopWr[i]   = wrStop[i] && !emptyQ[i] && !endEv[i];
      abortNow[i] = stopWr[i] && !busyQ[i] && !txStart[i];
      removeEv[i] = endEv[i] || abortNow[i];
      survive[i]  = !emptyQ[i] && !removeEv[i];

      strobe[i].setFin    = removeEv[i];
      strobe[i].setOk     = endEv[i] && (txResult == RES_OK);
      strobe[i].setArb    = endEv[i] && (txResult == RES_ARB);
      strobe[i].setErr    = endEv[i] && (txResult == RES_ERR);
      strobe[i].markEmpty = removeEv[i];
      strobe[i].markFull  = doLoad[i];
      strobe[i].setStop   = stopWr[i] && !abortNow[i];
      strobe[i].clrStop   = endEv[i];
    end
  end

  assign pendCnt = CNT_W'($countones(~emptyQ));
  assign survCnt = CNT_W'($countones(survive));

  // next rank: survivors close the gaps, new loads join at the tail in index order
  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      logic [CNT_W-1:0] shift;
      shift = '0;
      if (survive[i]) begin
        for (int j = 0; j < NUM_MB; j++)
          if (removeEv[j] && (rankQ[j] < rankQ[i])) shift = shift + 1'b1;
        rankD[i] = rankQ[i] - shift;
      end else if (doLoad[i]) begin
        for (int j = 0; j < i; j++)
          if (doLoad[j]) shift = shift + 1'b1;
        rankD[i] = survCnt + shift;
      end else begin
        rankD[i] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= '0;
      for (int i = 0; i < NUM_MB; i++) rankQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        rankQ[i] <= rankD[i];
        if (removeEv[i])                      busyQ[i] <= 1'b0;
        else if (txStart[i] && !emptyQ[i])    busyQ[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MB; i++)
      lastMb[i] = !emptyQ[i] && (pendCnt >= CNT_W'(2)) && (rankQ[i] == pendCnt - 1'b1);
  end

  generate
    for (genvar i = 0; i < NUM_MB; i++) begin : g_chk
      // R8: a started frame only exists on a pending mailbox
      p_busy_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
        busyQ[i] |-> !emptyQ[i]);
      for (genvar j = i + 1; j < NUM_MB; j++) begin : g_pair
        // R10: two pending mailboxes never share a queue position
        p_rank_unique_r10: assert property (@(posedge clk) disable iff (!rstN)
          (!emptyQ[i] && !emptyQ[j]) |-> (rankQ[i] != rankQ[j]));
      end
    end
  endgenerate

endmodule

// File: rtl/canTxFlagPath.sv
module canTxFlagPath
  import canTxPkg::*;
#(
  parameter int NUM_MB = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mbStrobe_t [NUM_MB-1:0] strobe,
  input  logic [31:0]            wrClr,
  input  logic [NUM_MB-1:0]      lastMb,
  output logic [NUM_MB-1:0]      emptyQ,
  output logic [31:0]            statusWord
);

  logic [NUM_MB-1:0] finQ, okQ, arbQ, errQ, stopQ;

  generate
    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
      localparam int BASE = i * SLOT_W;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          finQ[i]   <= 1'b0;
          okQ[i]    <= 1'b0;
          arbQ[i]   <= 1'b0;
          errQ[i]   <= 1'b0;
          stopQ[i]  <= 1'b0;
          emptyQ[i] <= 1'b1;
        end else begin
          if (strobe[i].setFin)              finQ[i] <= 1'b1;
          else if (wrClr[BASE + FIN_BIT])    finQ[i] <= 1'b0;
          if (strobe[i].setOk)               okQ[i]  <= 1'b1;
          else if (wrClr[BASE + OK_BIT])     okQ[i]  <= 1'b0;
          if (strobe[i].setArb)              arbQ[i] <= 1'b1;
          else if (wrClr[BASE + ARB_BIT])    arbQ[i] <= 1'b0;
          if (strobe[i].setErr)              errQ[i] <= 1'b1;
          else if (wrClr[BASE + ERR_BIT])    errQ[i] <= 1'b0;

          if (strobe[i].clrStop || strobe[i].markEmpty) stopQ[i] <= 1'b0;
          else if (strobe[i].setStop)                  stopQ[i] <= 1'b1;

          if (strobe[i].markEmpty)       emptyQ[i] <= 1'b1;
          else if (strobe[i].markFull)   emptyQ[i] <= 1'b0;
        end
      end

      // R6: a hardware set beats a same-cycle software clear
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
        (strobe[i].setFin && wrClr[BASE + FIN_BIT]) |=> finQ[i]);
      // R3: a load takes the mailbox out of the empty state
      p_load_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
        strobe[i].markFull |=> !emptyQ[i]);
      // R8: a held stop request stays until the frame ends
      p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
        (stopQ[i] && !strobe[i].clrStop && !strobe[i].markEmpty) |=> stopQ[i]);
      // R7: an abort empties the mailbox with the stop bit clear
      p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
        (strobe[i].markEmpty && !strobe[i].setOk && !strobe[i].setArb && !strobe[i].setErr)
          |=> (emptyQ[i] && finQ[i] && !stopQ[i]));
    end
  endgenerate

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      statusWord[i*SLOT_W + FIN_BIT]  = finQ[i];
      statusWord[i*SLOT_W + OK_BIT]   = okQ[i];
      statusWord[i*SLOT_W + ARB_BIT]  = arbQ[i];
      statusWord[i*SLOT_W + ERR_BIT]  = errQ[i];
      statusWord[i*SLOT_W + STOP_BIT] = stopQ[i];
      statusWord[EMPTY_BASE + i]      = emptyQ[i];
      statusWord[LAST_BASE + i]       = lastMb[i];
    end
  end

  // R10: at most one last flag, and only with two or more pending
  p_last_two_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lastMb != '0) |-> ($onehot0(lastMb) && ($countones(~emptyQ) >= 2)));

endmodule

// File: rtl/canTxStatus.sv
module canTxStatus
  import canTxPkg::*;
#(
  parameter int NUM_MB = 3,
  localparam int CNT_W = $clog2(NUM_MB + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_MB-1:0] mbLoad,
  input  logic [NUM_MB-1:0] txStart,
  input  logic [NUM_MB-1:0] txEnd,
  input  logic [1:0]        txResult,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       statusWord
);

  mbStrobe_t [NUM_MB-1:0] strobe;
  logic [NUM_MB-1:0]      emptyQ, lastMb, wrStop;
  logic [31:0]            wrClr;

  assign wrClr = regWrEn ? regWrData : 32'd0;

  generate
    for (genvar i = 0; i < NUM_MB; i++) begin : g_stop
      assign wrStop[i] = wrClr[i*SLOT_W + STOP_BIT];
    end
  endgenerate

  canTxOrderCtl #(.NUM_MB(NUM_MB), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .mbLoad(mbLoad), .txStart(txStart), .txEnd(txEnd),
    .txResult(txResult), .wrStop(wrStop), .emptyQ(emptyQ),
    .strobe(strobe), .lastMb(lastMb)
  );

  canTxFlagPath #(.NUM_MB(NUM_MB)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrClr(wrClr),
    .lastMb(lastMb), .emptyQ(emptyQ), .statusWord(statusWord)
  );

endmodule

// File: tb/canTxStatus_test.sv
module canTxStatus_test;

  typedef struct packed {
    logic [2:0]  ld;
    logic [2:0]  st;
    logic [2:0]  en;
    logic [1:0]  res;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'b001, 3'b000, 3'b000, 2'd0, 1'b0, 32'h0,        32'h1800_0000, 8'd3},  // R3 load mb0
    '{3'b100, 3'b000, 3'b000, 2'd0, 1'b0, 32'h0,        32'h8800_0000, 8'd10}, // R10 two pending, mb2 last
    '{3'b010, 3'b000, 3'b000, 2'd0, 1'b0, 32'h0,        32'h4000_0000, 8'd10}, // R10 mb1 last
    '{3'b010, 3'b000, 3'b000, 2'd0, 1'b0, 32'h0,        32'h4000_0000, 8'd3},  // R3 load on full ignored
    '{3'b000, 3'b001, 3'b000, 2'd0, 1'b0, 32'h0,        32'h4000_0000, 8'd8},  // R8 start mb0
    '{3'b000, 3'b000, 3'b001, 2'd0, 1'b0, 32'h0,        32'h4400_0003, 8'd4},  // R4 end ok, queue closes
    '{3'b000, 3'b000, 3'b000, 2'd0, 1'b1, 32'h0080_0000, 32'h1401_0003, 8'd7}, // R7 abort mb2
    '{3'b000, 3'b000, 3'b000, 2'd0, 1'b1, 32'h0000_0001, 32'h1401_0002, 8'd5}, // R5 w1c
    '{3'b000, 3'b000, 3'b000, 2'd0, 1'b1, 32'h0000_0000, 32'h1401_0002, 8'd5}, // R5 write 0
    '{3'b000, 3'b010, 3'b000, 2'd0, 1'b0, 32'h0,        32'h1401_0002, 8'd8},  // R8 start mb1
    '{3'b000, 3'b000, 3'b000, 2'd0, 1'b1, 32'h0000_8000, 32'h1401_8002, 8'd8}, // R8 stop held
    '{3'b000, 3'b000, 3'b010, 2'd1, 1'b0, 32'h0,        32'h1C01_0502, 8'd4},  // R4 arb lost, stop clears
    '{3'b000, 3'b000, 3'b000, 2'd0, 1'b1, 32'hFF00_0080, 32'h1C01_0502, 8'd9}, // R9 ignored writes
    '{3'b111, 3'b000, 3'b000, 2'd0, 1'b0, 32'h0,        32'h8001_0502, 8'd11}, // R11 joint load
    '{3'b000, 3'b000, 3'b100, 2'd2, 1'b0, 32'h0,        32'h5009_0502, 8'd2},  // R2 error bit, R10
    '{3'b000, 3'b000, 3'b010, 2'd0, 1'b1, 32'h0000_0F00, 32'h1809_0302, 8'd6}  // R6 set wins
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mbLoad = '0, txStart = '0, txEnd = '0;
  logic [1:0]  txResult = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] statusWord;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  canTxStatus uut (
    .clk(clk), .rstN(rstN), .mbLoad(mbLoad), .txStart(txStart), .txEnd(txEnd),
    .txResult(txResult), .regWrEn(regWrEn), .regWrData(regWrData),
    .statusWord(statusWord)
  );

  task automatic check(input logic [31:0] expv, input int req, input string what);
    checks++;
    if (statusWord !== expv) begin
      errors++;
      $display("FAIL R%0d %s: got %08h expected %08h", req, what, statusWord, expv);
    end
  endtask

  task automatic step(input vec_t v);
    mbLoad = v.ld; txStart = v.st; txEnd = v.en; txResult = v.res;
    regWrEn = v.wr; regWrData = v.wd;
    @(negedge clk);
    mbLoad = '0; txStart = '0; txEnd = '0; txResult = '0;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  initial begin
    @(negedge clk);
    check(32'h1C00_0000, 1, "during reset");                 // R1
    rstN = 1'b1;
    @(negedge clk);
    check(32'h1C00_0000, 1, "after reset");                  // R1
    for (int k = 0; k < NV; k++) begin
      step(VECS[k]);
      check(VECS[k].exp, int'(VECS[k].req), $sformatf("vector %0d", k));
    end
    // R1: reset again from a busy state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(32'h1C00_0000, 1, "re-reset");
    // R8: stop written in the start cycle is held, not an abort
    step('{3'b001, 3'b000, 3'b000, 2'd0, 1'b0, 32'h0, 32'h0, 8'd3});
    check(32'h1800_0000, 3, "load mb0");
    step('{3'b000, 3'b001, 3'b000, 2'd0, 1'b1, 32'h0000_0080, 32'h0, 8'd8});
    check(32'h1800_0080, 8, "stop with start");
    step('{3'b000, 3'b000, 3'b001, 2'd0, 1'b0, 32'h0, 32'h0, 8'd4});
    check(32'h1C00_0003, 8, "end clears stop");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule